// File: doc/BRIEF.md
# Decoded Boot/Table/Scratch Memory Unit

This block is the memory unit of a small accumulator datapath. It is addressed by a 5-bit word address taken from the address register, and it holds three devices of unequal size behind that one address. The two upper address bits choose the device. The lower bits pick a word inside the chosen device. The devices are a 16-word boot ROM, an 8-word table ROM and an 8-word scratch RAM, each 8 bits wide. The contents of both ROMs are fixed by parameters at build time. The RAM is cleared by reset.

A read strobe places the addressed word on the output lines. The output is combinational, so it appears in the same cycle. The shared data lines are modelled as a separate input bus, a separate output bus and a valid flag. When the flag is low, the output bus is treated as high impedance and reads as zero. A write strobe stores the input word into the RAM on the rising clock edge. A write aimed at either ROM has no effect on the contents. Instead, a small guard state machine raises an error flag for one cycle. Asserting read and write together counts as a clash: the write still happens and the output stays undriven.

The guard machine has two states. ST_CLEAN means the previous cycle held no rejected write. ST_FAULT means the previous cycle held a write to ROM space. Four transitions connect them. t_hold keeps ST_CLEAN when no ROM write occurs. t_reject goes from ST_CLEAN to ST_FAULT on a ROM write. t_repeat stays in ST_FAULT when another ROM write follows. t_recover goes from ST_FAULT back to ST_CLEAN otherwise. Each cycle is also classified by a command decode: CMD_IDLE (no strobe), CMD_READ (read only), CMD_WRITE (write only) or CMD_CLASH (both strobes).

Top module: `decoded_mem_unit`

## Requirements
- R1: The address map is as follows. Address bit 4 = 0 selects the boot ROM, indexed by bits 3..0. Addresses 0x10–0x17 (bit 4 = 1, bit 3 = 0) select the table ROM, indexed by bits 2..0. Addresses 0x18–0x1F (bit 4 = 1, bit 3 = 1) select the scratch RAM, indexed by bits 2..0.
- R2: Boot ROM word i equals bits [8i+7:8i] of parameter BOOT_IMAGE.
- R3: Table ROM word i equals bits [8i+7:8i] of parameter TABLE_IMAGE.
- R4: With rd = 1 and wr = 0, rdata carries the addressed word and rdata_vld = 1 in the same cycle. This also holds in the first cycle after reset, when address 0 shows boot word 0.
- R5: With rd = 0, rdata_vld = 0 and rdata = 0 (lines undriven).
- R6: With wr = 1 and an address in the RAM range, wdata is stored on the rising clock edge and reads back from the next cycle onward. A write to the RAM never raises wr_err.
- R7: Reset clears all eight RAM words to zero.
- R8: A write to either ROM range leaves the ROM contents unchanged. wr_err is 1 in exactly the cycle after each such write and 0 otherwise, including after reset.
- R9: With rd = 1 and wr = 1 together, rdata_vld = 0 and rdata = 0, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Word address from the address register |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Word to store |
| rdata | output | 8 | Read word, zero when undriven |
| rdata_vld | output | 1 | High when rdata drives the data lines |
| wr_err | output | 1 | One-cycle flag after a write to ROM space |

## Verification
The bench builds the block with its default geometry: PAGE_AW = 3 and DATA_W = 8. This makes the full 32-word address space small enough to sweep exhaustively. Both ROM images are supplied by the bench from simple arithmetic formulas, so every expected word is computed rather than stored. At this size, every region boundary can be reached, along with every RAM word, ROM write rejection in both ROM ranges, back-to-back ROM writes and the read/write clash.

// File: rtl/memu_pkg.sv
package memu_pkg;

    typedef enum logic [1:0] {
        RGN_BOOT    = 2'd0,
        RGN_TABLE   = 2'd1,
        RGN_SCRATCH = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_CLASH = 2'd3
    } cmd_e;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } guard_state_e;

    function automatic cmd_e classify_cmd(input logic rd, input logic wr);
        cmd_e c;
        unique case ({rd, wr})
            2'b00:   c = CMD_IDLE;
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            default: c = CMD_CLASH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/memu_addr_decoder.sv
module memu_addr_decoder
    import memu_pkg::*;
#(
    parameter int PAGE_AW = 3
) (
    input  logic [PAGE_AW+1:0] addr,
    output region_e            region,
    output logic [PAGE_AW:0]   offset
);
    localparam int MSB = PAGE_AW + 1;

    always_comb begin
        offset = addr[PAGE_AW:0];
        unique case ({addr[MSB], addr[MSB-1]})
            2'b00, 2'b01: region = RGN_BOOT;
            2'b10:        region = RGN_TABLE;
            default:      region = RGN_SCRATCH;
        endcase
    end
endmodule

// File: rtl/memu_rom_bank.sv
module memu_rom_bank #(
    parameter int AW     = 3,
    parameter int DATA_W = 8,
    parameter logic [(2**AW)*DATA_W-1:0] IMAGE = '0
) (
    input  logic [AW-1:0]     idx,
    output logic [DATA_W-1:0] word
);
    localparam int DEPTH = 2 ** AW;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign cells[g] = IMAGE[g*DATA_W +: DATA_W];
    end

    assign word = cells[idx];
endmodule

// File: rtl/memu_ram_bank.sv
module memu_ram_bank #(
    parameter int AW     = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/memu_write_guard.sv
module memu_write_guard
    import memu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rom_write,
    output logic fault
);
    guard_state_e state_q;
    guard_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAN: state_d = rom_write ? ST_FAULT : ST_CLEAN;  // t_reject / t_hold
            ST_FAULT: state_d = rom_write ? ST_FAULT : ST_CLEAN;  // t_repeat / t_recover
            default:  state_d = ST_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAN: fault = 1'b0;
            ST_FAULT: fault = 1'b1;
            default:  fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/decoded_mem_unit.sv
module decoded_mem_unit
    import memu_pkg::*;
#(
    parameter int PAGE_AW = 3,
    parameter int DATA_W  = 8,
    parameter logic [(2**(PAGE_AW+1))*DATA_W-1:0] BOOT_IMAGE  = '0,
    parameter logic [(2**PAGE_AW)*DATA_W-1:0]     TABLE_IMAGE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAGE_AW+1:0]  addr,
    input  logic                rd,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_vld,
    output logic                wr_err
);
    localparam int BOOT_AW = PAGE_AW + 1;

    region_e            region;
    logic [BOOT_AW-1:0] offset;
    logic [DATA_W-1:0]  boot_word;
    logic [DATA_W-1:0]  table_word;
    logic [DATA_W-1:0]  scratch_word;
    logic [DATA_W-1:0]  sel_word;
    logic               ram_we;
    logic               rom_write;
    cmd_e               cmd;

    memu_addr_decoder #(.PAGE_AW(PAGE_AW)) u_dec (
        .addr   (addr),
        .region (region),
        .offset (offset)
    );

    memu_rom_bank #(.AW(BOOT_AW), .DATA_W(DATA_W), .IMAGE(BOOT_IMAGE)) u_boot (
        .idx  (offset),
        .word (boot_word)
    );

    memu_rom_bank #(.AW(PAGE_AW), .DATA_W(DATA_W), .IMAGE(TABLE_IMAGE)) u_table (
        .idx  (offset[PAGE_AW-1:0]),
        .word (table_word)
    );

    memu_ram_bank #(.AW(PAGE_AW), .DATA_W(DATA_W)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .idx   (offset[PAGE_AW-1:0]),
        .wdata (wdata),
        .rdata (scratch_word)
    );

    memu_write_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .rom_write (rom_write),
        .fault     (wr_err)
    );

    assign cmd       = classify_cmd(rd, wr);
    assign ram_we    = wr && (region == RGN_SCRATCH);
    assign rom_write = wr && (region != RGN_SCRATCH);

    always_comb begin
        unique case (region)
            RGN_BOOT:    sel_word = boot_word;
            RGN_TABLE:   sel_word = table_word;
            RGN_SCRATCH: sel_word = scratch_word;
            default:     sel_word = '0;
        endcase
    end

    always_comb begin
        unique case (cmd)
            CMD_READ: begin
                rdata     = sel_word;
                rdata_vld = 1'b1;
            end
            CMD_IDLE, CMD_WRITE, CMD_CLASH: begin
                rdata     = '0;
                rdata_vld = 1'b0;
            end
            default: begin
                rdata     = '0;
                rdata_vld = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/memu_checker.sv
module memu_checker #(
    parameter int PAGE_AW = 3,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PAGE_AW+1:0] addr,
    input logic               rd,
    input logic               wr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic               rdata_vld,
    input logic               wr_err
);
    localparam int MSB = PAGE_AW + 1;

    logic in_ram;
    logic in_boot;
    assign in_ram  = addr[MSB] && addr[MSB-1];
    assign in_boot = !addr[MSB];

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |-> rdata_vld) else $error("read not driven");  // R4

    AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (!rdata_vld && rdata == '0)) else $error("idle driven");  // R5

    AST_CLASH_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |-> (!rdata_vld && rdata == '0)) else $error("clash driven");  // R9

    AST_ROM_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !in_ram) |=> wr_err) else $error("rom write not flagged");  // R8

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(rst_n && wr && !in_ram)) else $error("spurious flag");  // R8

    AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && wr && in_ram) && rd && !wr && addr == $past(addr))
        |-> rdata == $past(wdata)) else $error("ram write lost");  // R6

    AST_BOOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && rd && !wr) && rd && !wr && in_boot && addr == $past(addr))
        |-> $stable(rdata)) else $error("boot word changed");  // R2
endmodule

bind decoded_mem_unit memu_checker #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) u_memu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd        (rd),
    .wr        (wr),
    .wdata     (wdata),
    .rdata     (rdata),
    .rdata_vld (rdata_vld),
    .wr_err    (wr_err)
);

// File: tb/test_decoded_mem_unit.sv
module test_decoded_mem_unit;
    localparam int PAGE_AW = 3;
    localparam int DATA_W  = 8;
    localparam int BOOT_N  = 2 ** (PAGE_AW + 1);
    localparam int PAGE_N  = 2 ** PAGE_AW;

    function automatic logic [7:0] boot_w(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction
    function automatic logic [7:0] table_w(input int i);
        return 8'(((i * 13) ^ 8'hC3) & 255);
    endfunction
    function automatic logic [7:0] ram_w(input int i);
        return 8'((i * 29 + 71) & 255);
    endfunction
    function automatic logic [BOOT_N*8-1:0] mk_boot();
        logic [BOOT_N*8-1:0] v;
        for (int i = 0; i < BOOT_N; i++) v[i*8 +: 8] = boot_w(i);
        return v;
    endfunction
    function automatic logic [PAGE_N*8-1:0] mk_table();
        logic [PAGE_N*8-1:0] v;
        for (int i = 0; i < PAGE_N; i++) v[i*8 +: 8] = table_w(i);
        return v;
    endfunction

    localparam logic [BOOT_N*8-1:0] BOOT_IMG  = mk_boot();
    localparam logic [PAGE_N*8-1:0] TABLE_IMG = mk_table();

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] addr;
    logic       rd, wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rdata_vld;
    logic       wr_err;
    int         n_run = 0;
    int         n_fail = 0;
    int         cycles = 0;

    always #5 clk = ~clk;

    decoded_mem_unit #(
        .PAGE_AW(PAGE_AW), .DATA_W(DATA_W),
        .BOOT_IMAGE(BOOT_IMG), .TABLE_IMAGE(TABLE_IMG)
    ) i_decoded_mem_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .wr_err(wr_err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // advance to just after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] expect_word(input int a, input logic [7:0] ram [PAGE_N]);
        if (a < 16) return boot_w(a);
        else if (a < 24) return table_w(a - 16);
        else return ram[a - 24];
    endfunction

    task automatic sweep_read(input logic [7:0] ram [PAGE_N], input string tag);
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a); rd = 1'b1; wr = 1'b0;
            #1;
            check(rdata_vld && rdata == expect_word(a, ram), tag, rdata, expect_word(a, ram));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] shadow [PAGE_N];
        for (int i = 0; i < PAGE_N; i++) shadow[i] = 8'h00;
        rst_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
        repeat (3) tick();
        check(!rdata_vld && rdata == 8'h00, "R5 reset idle", rdata_vld, 0);
        check(!wr_err, "R8 reset flag", wr_err, 0);
        rst_n = 1'b1;
        rd = 1'b1; #1;
        check(rdata_vld && rdata == boot_w(0), "R4 addr0 after reset", rdata, boot_w(0));

        // R1 R2 R3 R4 R7: full map sweep with cleared RAM
        sweep_read(shadow, "R1/R2/R3/R7 map sweep");

        // R5: idle sweep
        for (int a = 0; a < 32; a += 3) begin
            addr = 5'(a); rd = 1'b0; wr = 1'b0; #1;
            check(!rdata_vld && rdata == 8'h00, "R5 idle", rdata, 0);
        end

        // R6: fill every RAM word
        for (int k = 0; k < PAGE_N; k++) begin
            addr = 5'(24 + k); wdata = ram_w(k); wr = 1'b1; rd = 1'b0;
            shadow[k] = ram_w(k);
            tick();
            check(!wr_err, "R6 ram write no flag", wr_err, 0);
        end
        wr = 1'b0;
        sweep_read(shadow, "R6 ram readback");

        // R8: single write to boot ROM
        addr = 5'd5; wdata = ~boot_w(5); wr = 1'b1; rd = 1'b0;
        tick();
        wr = 1'b0; rd = 1'b1; #1;
        check(wr_err, "R8 boot write flag", wr_err, 1);
        check(rdata == boot_w(5), "R8 boot unchanged", rdata, boot_w(5));
        tick();
        check(!wr_err, "R8 flag one cycle", wr_err, 0);

        // R8: back-to-back writes to table ROM
        addr = 5'h12; wdata = 8'h00; wr = 1'b1; rd = 1'b0;
        tick();
        check(wr_err, "R8 table write flag", wr_err, 1);
        addr = 5'h17;
        tick();
        check(wr_err, "R8 repeat flag", wr_err, 1);
        wr = 1'b0;
        tick();
        check(!wr_err, "R8 recover", wr_err, 0);
        sweep_read(shadow, "R8 roms intact");

        // R9: clash writes RAM, output undriven
        addr = 5'h1A; wdata = 8'h5A; rd = 1'b1; wr = 1'b1; #1;
        check(!rdata_vld && rdata == 8'h00, "R9 clash undriven", rdata, 0);
        shadow[2] = 8'h5A;
        tick();
        wr = 1'b0; #1;
        check(rdata_vld && rdata == 8'h5A, "R9 clash write landed", rdata, 8'h5A);
        check(!wr_err, "R9 clash ram no flag", wr_err, 0);

        // R7: reset clears RAM again
        rst_n = 1'b0; rd = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < PAGE_N; i++) shadow[i] = 8'h00;
        sweep_read(shadow, "R7 ram cleared by reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule